// File: doc/BRIEF.md
# Start/Done Handshake Accelerator Wrapper

This block lets a hand-written datapath, such as a transform core, be called like a synthesized function. A caller raises `start_i`. The wrapper then copies an input vector of `DEPTH` words from a source memory port into a local operand buffer. It fires the core with a single-cycle `core_go_o` and waits for the core's completion pulse. Finally it streams the `DEPTH` result words out of a local result buffer to a destination memory port. The block-level handshake has four signals. `idle_o` shows that nothing is in flight. `ready_o` marks the cycle after which the source may be reused. `done_o` marks the final output beat. Holding `start_i` through `done_o` chains the next call with no idle cycle between.

Internally a four-phase sequencer (wait, fetch, compute, emit) owns one shared word index. That index drives the source read address, the operand buffer write address, the result buffer read address and the destination write address. While the core runs it reads the operand buffer and writes the result buffer through its own ports. The core's arithmetic is not part of this block.

Top module: `kernel_call_wrapper`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `idle_o` is 1 and `done_o`, `ready_o`, `src_rd_o`, `dst_wr_o` and `core_go_o` are all 0.
- R2: The wrapper leaves the waiting phase only at a clock edge where it is idle and `start_i` is 1. In the next cycle `src_rd_o` is 1 with `src_addr_o` = 0. An idle wrapper with `start_i` low stays idle.
- R3: The fetch phase lasts exactly `DEPTH` consecutive cycles. Each cycle has `src_rd_o` = 1, with `src_addr_o` rising by one from 0 to `DEPTH-1`. `src_data_i` is sampled in the same cycle as its address, and word k is stored at operand buffer index k.
- R4: `ready_o` is high for exactly one cycle, the cycle of the read of address `DEPTH-1`. `core_go_o` is high for exactly one cycle, the cycle right after.
- R5: After `core_go_o`, the wrapper waits any number of cycles for `core_fin_i`. The first `dst_wr_o` beat occurs in the cycle after `core_fin_i` is sampled high.
- R6: The emit phase lasts exactly `DEPTH` consecutive cycles. Each cycle has `dst_wr_o` = 1, with `dst_addr_o` rising by one from 0 to `DEPTH-1`. `dst_data_o` equals the result buffer word at that index.
- R7: `done_o` is high for exactly one cycle, the cycle of the destination write to address `DEPTH-1`.
- R8: `idle_o` is 1 only in the waiting phase. While it is 1, none of `src_rd_o`, `dst_wr_o`, `core_go_o`, `ready_o` or `done_o` is high.
- R9: If `start_i` is 1 in the `done_o` cycle, the next cycle is the first fetch cycle (address 0) with `idle_o` low. Otherwise the next cycle is idle.
- R10: `start_i` has no effect while a call is in progress, except in the `done_o` cycle. Holding it high leaves every phase length unchanged.
- R11: `core_wr_en_i` writes into the result buffer only during the compute phase. A `core_fin_i` pulse outside the compute phase is ignored, so the wrapper stays idle and emits nothing.
- R12: During the compute phase, `core_rd_data_o` returns, without a clock delay, the operand word stored at index `core_rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a call |
| idle_o | output | 1 | No call in progress |
| done_o | output | 1 | Last output beat of a call |
| ready_o | output | 1 | Last input read; source may change afterwards |
| src_rd_o | output | 1 | Source read strobe |
| src_addr_o | output | ADDR_W | Source word address |
| src_data_i | input | DATA_W | Source word, valid in the cycle of its address |
| dst_wr_o | output | 1 | Destination write strobe |
| dst_addr_o | output | ADDR_W | Destination word address |
| dst_data_o | output | DATA_W | Destination word |
| core_go_o | output | 1 | One-cycle launch pulse to the core |
| core_fin_i | input | 1 | Core completion pulse |
| core_rd_addr_i | input | ADDR_W | Core read index into the operand buffer |
| core_rd_data_o | output | DATA_W | Operand word at that index |
| core_wr_en_i | input | 1 | Core write strobe into the result buffer |
| core_wr_addr_i | input | ADDR_W | Core write index into the result buffer |
| core_wr_data_i | input | DATA_W | Core result word |

## Verification
The bound checker watches the port-level ordering on every cycle. It checks the launch out of idle and the address stepping of both streams. It also checks that `ready_o` leads `core_go_o`, that both pulses and `done_o` last one cycle, that `done_o` lands on the last write, that an idle wrapper raises no strobe, and how `start_i` in the `done_o` cycle is resolved. Only the bench can measure the data path and the cycle counts against a stub core with a programmable delay. Those cover operand capture, result contents, the distance from `core_fin_i` to the first output beat, back-to-back chaining, and the proof that stray core writes and completion pulses outside the compute phase leave the outputs untouched.

// File: rtl/kcw_pkg.sv
`timescale 1ns/1ps
package kcw_pkg;

    // Phase of a call; the order of the encodings carries no meaning.
    typedef enum logic [1:0] {
        PH_WAIT    = 2'd0,
        PH_FETCH   = 2'd1,
        PH_COMPUTE = 2'd2,
        PH_EMIT    = 2'd3
    } phase_e;

    // Index width for a buffer of the given depth.
    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/kcw_sequencer.sv
`timescale 1ns/1ps
module kcw_sequencer
    import kcw_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int IDX_W = kcw_pkg::idx_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fin_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output logic             kick_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic             kick;
    } seq_s;

    seq_s cur_q;
    seq_s nxt_d;
    logic at_last;

    assign at_last = (cur_q.idx == IDX_LAST);

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.kick = 1'b0;
        case (cur_q.ph)
            PH_WAIT: begin
                if (start_i) begin
                    nxt_d.ph  = PH_FETCH;
                    nxt_d.idx = '0;
                end
            end
            PH_FETCH: begin
                if (at_last) begin
                    // Operands are complete: launch the core next cycle.
                    nxt_d.ph   = PH_COMPUTE;
                    nxt_d.idx  = '0;
                    nxt_d.kick = 1'b1;
                end else begin
                    nxt_d.idx = cur_q.idx + IDX_ONE;
                end
            end
            PH_COMPUTE: begin
                if (fin_i) begin
                    nxt_d.ph  = PH_EMIT;
                    nxt_d.idx = '0;
                end
            end
            PH_EMIT: begin
                if (at_last) begin
                    // A start seen on the final beat chains the next call.
                    nxt_d.ph  = start_i ? PH_FETCH : PH_WAIT;
                    nxt_d.idx = '0;
                end else begin
                    nxt_d.idx = cur_q.idx + IDX_ONE;
                end
            end
            default: begin
                nxt_d.ph  = PH_WAIT;
                nxt_d.idx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{ph: PH_WAIT, idx: '0, kick: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign phase_o = cur_q.ph;
    assign idx_o   = cur_q.idx;
    assign last_o  = at_last;
    assign kick_o  = cur_q.kick;

endmodule

// File: rtl/kcw_buffer.sv
`timescale 1ns/1ps
module kcw_buffer #(
    parameter  int DEPTH  = 256,
    parameter  int DATA_W = 16,
    localparam int IDX_W  = kcw_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // One registered write port, one combinational read port.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/kernel_call_wrapper.sv
`timescale 1ns/1ps
module kernel_call_wrapper
    import kcw_pkg::*;
#(
    parameter  int DEPTH  = 256,
    parameter  int DATA_W = 16,
    localparam int ADDR_W = kcw_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              idle_o,
    output logic              done_o,
    output logic              ready_o,
    output logic              src_rd_o,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              dst_wr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [DATA_W-1:0] dst_data_o,
    output logic              core_go_o,
    input  logic              core_fin_i,
    input  logic [ADDR_W-1:0] core_rd_addr_i,
    output logic [DATA_W-1:0] core_rd_data_o,
    input  logic              core_wr_en_i,
    input  logic [ADDR_W-1:0] core_wr_addr_i,
    input  logic [DATA_W-1:0] core_wr_data_i
);

    phase_e            phase;
    logic [ADDR_W-1:0] idx;
    logic              idx_last;
    logic              kick;
    logic              in_fetch;
    logic              in_compute;
    logic              in_emit;
    logic              core_fin_gated;
    logic              res_wr_en;
    logic [DATA_W-1:0] res_word;

    kcw_sequencer #(
        .DEPTH (DEPTH)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .fin_i   (core_fin_gated),
        .phase_o (phase),
        .idx_o   (idx),
        .last_o  (idx_last),
        .kick_o  (kick)
    );

    assign in_fetch   = (phase == PH_FETCH);
    assign in_compute = (phase == PH_COMPUTE);
    assign in_emit    = (phase == PH_EMIT);

    // Completion and result writes only count while the core owns the buffers.
    assign core_fin_gated = core_fin_i & in_compute;
    assign res_wr_en      = core_wr_en_i & in_compute;

    // Operand buffer: filled from the source stream, read by the core.
    kcw_buffer #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) opnd_buf_i (
        .clk       (clk),
        .wr_en_i   (in_fetch),
        .wr_idx_i  (idx),
        .wr_data_i (src_data_i),
        .rd_idx_i  (core_rd_addr_i),
        .rd_data_o (core_rd_data_o)
    );

    // Result buffer: filled by the core, drained to the destination stream.
    kcw_buffer #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) rslt_buf_i (
        .clk       (clk),
        .wr_en_i   (res_wr_en),
        .wr_idx_i  (core_wr_addr_i),
        .wr_data_i (core_wr_data_i),
        .rd_idx_i  (idx),
        .rd_data_o (res_word)
    );

    assign idle_o     = (phase == PH_WAIT);
    assign ready_o    = in_fetch & idx_last;
    assign done_o     = in_emit & idx_last;
    assign src_rd_o   = in_fetch;
    assign src_addr_o = idx;
    assign dst_wr_o   = in_emit;
    assign dst_addr_o = idx;
    assign dst_data_o = res_word;
    assign core_go_o  = kick;

endmodule

// File: rtl/kcw_checker.sv
`timescale 1ns/1ps
module kcw_checker #(
    parameter  int DEPTH  = 256,
    localparam int ADDR_W = kcw_pkg::idx_width(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              idle_o,
    input logic              done_o,
    input logic              ready_o,
    input logic              src_rd_o,
    input logic [ADDR_W-1:0] src_addr_o,
    input logic              dst_wr_o,
    input logic [ADDR_W-1:0] dst_addr_o,
    input logic              core_go_o
);

    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);

    a_r2_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (idle_o && !start_i) |=> idle_o);

    a_r2_launch: assert property (@(posedge clk) disable iff (rst)
        (idle_o && start_i) |=> (src_rd_o && src_addr_o == '0 && !idle_o));

    a_r3_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (src_rd_o && src_addr_o != A_LAST) |=>
            (src_rd_o && src_addr_o == $past(src_addr_o) + A_ONE));

    a_r4_ready_on_last: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (src_rd_o && src_addr_o == A_LAST));

    a_r4_go_after_ready: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> (core_go_o && !ready_o));

    a_r4_go_single: assert property (@(posedge clk) disable iff (rst)
        core_go_o |=> !core_go_o);

    a_r6_emit_step: assert property (@(posedge clk) disable iff (rst)
        (dst_wr_o && dst_addr_o != A_LAST) |=>
            (dst_wr_o && dst_addr_o == $past(dst_addr_o) + A_ONE));

    a_r7_done_on_last: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (dst_wr_o && dst_addr_o == A_LAST));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> !(src_rd_o || dst_wr_o || core_go_o || ready_o || done_o));

    a_r9_chain: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> (src_rd_o && src_addr_o == '0 && !idle_o));

    a_r9_return: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> idle_o);

endmodule

bind kernel_call_wrapper kcw_checker #(
    .DEPTH (DEPTH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .idle_o     (idle_o),
    .done_o     (done_o),
    .ready_o    (ready_o),
    .src_rd_o   (src_rd_o),
    .src_addr_o (src_addr_o),
    .dst_wr_o   (dst_wr_o),
    .dst_addr_o (dst_addr_o),
    .core_go_o  (core_go_o)
);

// File: tb/kernel_call_wrapper_tb_top.sv
`timescale 1ns/1ps
module kernel_call_wrapper_tb_top;

    localparam int D  = 16;
    localparam int W  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          idle_o, done_o, ready_o;
    logic          src_rd_o, dst_wr_o, core_go_o;
    logic [AW-1:0] src_addr_o, dst_addr_o;
    logic [W-1:0]  src_data_i, dst_data_o, core_rd_data_o;
    logic          core_fin_i = 1'b0;
    logic [AW-1:0] core_rd_addr_i = '0;
    logic          core_wr_en_i = 1'b0;
    logic [AW-1:0] core_wr_addr_i = '0;
    logic [W-1:0]  core_wr_data_i = '0;

    logic [W-1:0]  src_mem [D];
    logic [W-1:0]  exp_out [D];

    int  n_chk = 0, n_bad = 0, cyc = 0;
    int  rd_cnt, rd_first, wr_cnt, wr_first;
    int  ready_cyc, go_cyc, fin_cyc, done_cyc, done_n, last_done;
    bit  done_seen;
    int  stub_dly = 0;
    bit  stub_skip0 = 1'b0;
    bit  poke_req = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign src_data_i = src_mem[src_addr_o];

    kernel_call_wrapper #(.DEPTH(D), .DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .idle_o(idle_o), .done_o(done_o), .ready_o(ready_o),
        .src_rd_o(src_rd_o), .src_addr_o(src_addr_o), .src_data_i(src_data_i),
        .dst_wr_o(dst_wr_o), .dst_addr_o(dst_addr_o), .dst_data_o(dst_data_o),
        .core_go_o(core_go_o), .core_fin_i(core_fin_i),
        .core_rd_addr_i(core_rd_addr_i), .core_rd_data_o(core_rd_data_o),
        .core_wr_en_i(core_wr_en_i), .core_wr_addr_i(core_wr_addr_i),
        .core_wr_data_i(core_wr_data_i)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [W-1:0] fx(input logic [W-1:0] x, input int i);
        return (x ^ 16'hA5A5) + W'(i * 3);
    endfunction

    // Stub core: copies f(operand) into the result buffer, then waits stub_dly.
    initial begin
        forever begin
            @(negedge clk);
            if (core_go_o) begin
                for (int i = 0; i < D; i++) begin
                    @(negedge clk);
                    core_rd_addr_i = AW'(i);
                    #0.2;
                    core_wr_addr_i = AW'(i);
                    core_wr_data_i = fx(core_rd_data_o, i); // R12 operand read
                    core_wr_en_i   = !(stub_skip0 && i == 0);
                end
                @(negedge clk);
                core_wr_en_i = 1'b0;
                repeat (stub_dly) @(negedge clk);
                core_fin_i = 1'b1;
                @(negedge clk);
                core_fin_i = 1'b0;
            end else if (poke_req) begin
                core_wr_en_i   = 1'b1;
                core_wr_addr_i = '0;
                core_wr_data_i = 16'hBEEF;
                core_fin_i     = 1'b1;
                poke_req       = 1'b0;
            end else begin
                core_wr_en_i = 1'b0;
                core_fin_i   = 1'b0;
            end
        end
    end

    // Port monitor, sampled mid-cycle.
    always @(negedge clk) begin
        #0.5;
        if (!rst) begin
            if (src_rd_o) begin
                if (rd_cnt == 0) rd_first = cyc;
                chk(src_addr_o == AW'(rd_cnt), "R3 source address", src_addr_o, rd_cnt);
                rd_cnt++;
            end
            if (ready_o)    ready_cyc = cyc;
            if (core_go_o)  go_cyc = cyc;
            if (core_fin_i && !idle_o) fin_cyc = cyc;
            if (dst_wr_o) begin
                if (wr_cnt == 0) wr_first = cyc;
                chk(dst_addr_o == AW'(wr_cnt), "R6 destination address", dst_addr_o, wr_cnt);
                if (wr_cnt < D)
                    chk(dst_data_o == exp_out[wr_cnt], "R6 R12 destination data",
                        dst_data_o, exp_out[wr_cnt]);
                wr_cnt++;
            end
            if (done_o) begin
                done_cyc  = cyc;
                done_n++;
                done_seen = 1'b1;
            end
        end
    end

    task automatic prepare(input int n, input int dly, input bit skip0);
        for (int i = 0; i < D; i++) begin
            src_mem[i] = W'(i * 37 + n * 1013 + 7);
            if (!(skip0 && i == 0)) exp_out[i] = fx(src_mem[i], i);
        end
        stub_dly   = dly;
        stub_skip0 = skip0;
        rd_cnt = 0; wr_cnt = 0; done_n = 0; done_seen = 1'b0;
    endtask

    task automatic run(input bit chained, input bit hold, input int dly);
        int t_s;
        if (!chained) begin
            @(negedge clk);
            chk(idle_o == 1'b1, "R8 idle before start", idle_o, 1);
            start_i = 1'b1;
            t_s = cyc;
        end else begin
            t_s = last_done;
        end
        if (!hold) begin
            @(negedge clk);
            start_i = 1'b0;
        end
        do begin
            @(negedge clk);
            #1;
        end while (!done_seen);
        chk(rd_first == t_s + 1, "R2 R9 first read cycle", rd_first, t_s + 1);
        chk(rd_cnt == D, "R3 R10 read count", rd_cnt, D);
        chk(ready_cyc == t_s + D, "R4 ready cycle", ready_cyc, t_s + D);
        chk(go_cyc == t_s + D + 1, "R4 go cycle", go_cyc, t_s + D + 1);
        chk(fin_cyc == go_cyc + D + 1 + dly, "R5 completion cycle", fin_cyc, go_cyc + D + 1 + dly);
        chk(wr_first == fin_cyc + 1, "R5 first write cycle", wr_first, fin_cyc + 1);
        chk(wr_cnt == D, "R6 R10 write count", wr_cnt, D);
        chk(done_cyc == fin_cyc + D, "R7 done cycle", done_cyc, fin_cyc + D);
        chk(done_n == 1, "R7 single done", done_n, 1);
        last_done = done_cyc;
        if (!hold) begin
            @(negedge clk);
            chk(idle_o == 1'b1, "R9 idle after done", idle_o, 1);
        end
    endtask

    initial begin
        #(4.0 * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(idle_o && !done_o && !ready_o && !src_rd_o && !dst_wr_o && !core_go_o,
            "R1 state during reset", {idle_o, done_o, ready_o, src_rd_o, dst_wr_o, core_go_o}, 32);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(idle_o && !done_o && !ready_o && !src_rd_o && !dst_wr_o && !core_go_o,
            "R1 R2 idle without start", {idle_o, done_o, ready_o, src_rd_o, dst_wr_o, core_go_o}, 32);

        prepare(1, 3, 1'b0);  run(1'b0, 1'b0, 3);
        prepare(2, 0, 1'b0);  run(1'b0, 1'b0, 0);
        prepare(3, 7, 1'b0);  run(1'b0, 1'b1, 7);   // start held: R10 then R9 chain
        prepare(4, 2, 1'b0);  run(1'b1, 1'b0, 2);

        // R11: stray result write and completion pulse while idle
        wr_cnt = 0;
        @(negedge clk);
        #1 poke_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(idle_o == 1'b1, "R11 fin ignored while idle", idle_o, 1);
        chk(wr_cnt == 0, "R11 no output beats while idle", wr_cnt, 0);
        repeat (3) @(negedge clk);
        chk(idle_o == 1'b1, "R11 still idle", idle_o, 1);

        // core skips index 0, so the stale value must come out unchanged
        prepare(5, 1, 1'b1);  run(1'b0, 1'b0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule